// File: doc/BRIEF.md
# Syscall Interrupt Privilege Gate

This block sits between a small soft CPU's data bus and two protected memories: a firmware RAM and a boot ROM. It tracks which of four execution contexts is active: firmware, application, low-level syscall handler or high-level syscall handler. It turns that context into two enables.

The firmware RAM is usable in firmware mode and inside the high-level syscall handler. In application mode and inside the low-level handler it is invisible: reads return zero and writes do not reach the memory. The boot ROM may be executed in every context except application mode.

Software enters a syscall by writing any value to one of two trigger addresses. The block raises a one-cycle interrupt request for that level. It also marks the level as active until the CPU reports a return from interrupt. A sticky input moves the system from firmware mode into application mode; only reset brings it back.

Top module: `syscall_priv_gate`

## Requirements
- R1: After synchronous reset the block is in firmware mode: `app_mode`=0, `irq_hi`=0, `irq_lo`=0, `bus_ready`=0, and both `ram_en` and `rom_exec_en` are 1.
- R2: A bus write (`bus_cs`=1, any nonzero `bus_we`) to address 0xE100_0000 drives `irq_hi` to 1 in the following cycle only, whatever the written data.
- R3: A bus write to address 0xE000_0000 drives `irq_lo` to 1 in the following cycle only, whatever the written data.
- R4: A trigger write sets its access level from the next cycle on. A cycle with `irq_ret`=1 clears both levels from the next cycle on. If a trigger and `irq_ret` fall in the same cycle, the trigger wins.
- R5: `ram_en` is 1 exactly when the block is in firmware mode or the high level is active.
- R6: `rom_exec_en` is 1 exactly when the block is in firmware mode or either level is active.
- R7: For an access whose address has top byte 0xD0, `ram_cs` equals `bus_cs` and `ram_we` equals `bus_we` in the same cycle while `ram_en` is 1. While `ram_en` is 0, both `ram_cs` and `ram_we` are 0.
- R8: In the cycle after a permitted firmware-RAM read, `bus_rdata` equals `ram_rdata`. After a read that is not permitted, `bus_rdata` is 0.
- R9: `bus_ready` is 1 in the cycle after every cycle with `bus_cs`=1, including masked accesses, and 0 otherwise.
- R10: A cycle with `app_enter`=1 sets `app_mode` from the next cycle on. It stays set until reset.
- R11: A read (`bus_we`=0) from either trigger address raises no interrupt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| app_enter | input | 1 | Switch to application mode (sticky) |
| irq_ret | input | 1 | CPU returned from interrupt |
| bus_cs | input | 1 | Bus access strobe |
| bus_we | input | 4 | Byte write strobes; 0 means read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Gated firmware-RAM read data |
| bus_ready | output | 1 | Access completion, one cycle after strobe |
| irq_hi | output | 1 | High-level syscall request pulse |
| irq_lo | output | 1 | Low-level syscall request pulse |
| app_mode | output | 1 | Application mode flag |
| ram_en | output | 1 | Firmware RAM permitted |
| rom_exec_en | output | 1 | Boot ROM execution permitted |
| ram_cs | output | 1 | Qualified firmware RAM select |
| ram_we | output | 4 | Qualified firmware RAM byte strobes |
| ram_addr | output | 9 | Firmware RAM word address |
| ram_wdata | output | 32 | Firmware RAM write data |
| ram_rdata | input | 32 | Firmware RAM read data (one cycle latency) |

## Verification
The same firmware-RAM read and write are issued in each of the four contexts. A difference in `ram_cs`, `ram_we` or `bus_rdata` then comes only from the context, which separates the high-level handler from the low-level one. Trigger writes are sent with all-zero and all-one data, so a decode that depends on data is exposed. A read of a trigger address shows whether the decode ignores the write strobe. A trigger and a return in the same cycle fix the priority between them. Masked accesses are checked for a ready pulse exactly like permitted ones.

// File: rtl/spg_pkg.sv
package spg_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int STRB_W = DATA_W / 8;
    localparam int RAM_AW = 9;

    localparam logic [31:0] TRIG_HI_ADDR = 32'hE100_0000;
    localparam logic [31:0] TRIG_LO_ADDR = 32'hE000_0000;
    localparam logic [31:0] FWRAM_BASE   = 32'hD000_0000;
    localparam logic [31:0] FWRAM_MASK   = 32'hFF00_0000;

    typedef struct packed {
        logic hi;
        logic lo;
    } lvl_t;

    typedef struct packed {
        logic trig_hi;
        logic trig_lo;
        logic in_ram;
        logic is_wr;
    } dec_t;

    function automatic logic in_region(input logic [31:0] a,
                                       input logic [31:0] base,
                                       input logic [31:0] mask);
        return (a & mask) == base;
    endfunction
endpackage

// File: rtl/spg_decode.sv
module spg_decode
    import spg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = STRB_W
) (
    input  logic          cs,
    input  logic [SW-1:0] we,
    input  logic [AW-1:0] addr,
    output dec_t          dec
);
    logic [31:0] a32;

    always_comb begin
        a32         = 32'(addr);
        dec.is_wr   = |we;
        dec.trig_hi = cs && dec.is_wr && (a32 == TRIG_HI_ADDR);
        dec.trig_lo = cs && dec.is_wr && (a32 == TRIG_LO_ADDR);
        dec.in_ram  = in_region(a32, FWRAM_BASE, FWRAM_MASK);
    end
endmodule

// File: rtl/spg_ctx.sv
module spg_ctx
    import spg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic app_enter,
    input  logic irq_ret,
    input  dec_t dec,
    output logic irq_hi,
    output logic irq_lo,
    output logic app_mode,
    output logic ram_en,
    output logic rom_exec_en
);
    logic app_q;
    lvl_t lvl_q;
    logic irq_hi_q, irq_lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            app_q    <= 1'b0;
            lvl_q    <= '0;
            irq_hi_q <= 1'b0;
            irq_lo_q <= 1'b0;
        end else begin
            app_q    <= app_q | app_enter;
            lvl_q.hi <= dec.trig_hi | (lvl_q.hi & ~irq_ret);
            lvl_q.lo <= dec.trig_lo | (lvl_q.lo & ~irq_ret);
            irq_hi_q <= dec.trig_hi;
            irq_lo_q <= dec.trig_lo;
        end
    end

    assign irq_hi      = irq_hi_q;
    assign irq_lo      = irq_lo_q;
    assign app_mode    = app_q;
    assign ram_en      = ~app_q | lvl_q.hi;
    assign rom_exec_en = ~app_q | lvl_q.hi | lvl_q.lo;
endmodule

// File: rtl/spg_ramgate.sv
module spg_ramgate
    import spg_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int SW  = STRB_W,
    parameter int RAW = RAM_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ram_en,
    input  dec_t           dec,
    input  logic           bus_cs,
    input  logic [SW-1:0]  bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_ready,
    output logic           ram_cs,
    output logic [SW-1:0]  ram_we,
    output logic [RAW-1:0] ram_addr,
    output logic [DW-1:0]  ram_wdata,
    input  logic [DW-1:0]  ram_rdata
);
    localparam int WORD_LSB = $clog2(SW);

    logic sel_ok;
    logic rd_ok_q;
    logic ready_q;

    assign sel_ok    = bus_cs && dec.in_ram && ram_en;
    assign ram_cs    = sel_ok;
    assign ram_we    = sel_ok ? bus_we : '0;
    assign ram_addr  = bus_addr[RAW+WORD_LSB-1:WORD_LSB];
    assign ram_wdata = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ok_q <= 1'b0;
            ready_q <= 1'b0;
        end else begin
            rd_ok_q <= sel_ok && !dec.is_wr;
            ready_q <= bus_cs;
        end
    end

    assign bus_rdata = rd_ok_q ? ram_rdata : '0;
    assign bus_ready = ready_q;
endmodule

// File: rtl/syscall_priv_gate.sv
module syscall_priv_gate
    import spg_pkg::*;
#(
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int SW  = DW / 8,
    parameter int RAW = RAM_AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           app_enter,
    input  logic           irq_ret,
    input  logic           bus_cs,
    input  logic [SW-1:0]  bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           bus_ready,
    output logic           irq_hi,
    output logic           irq_lo,
    output logic           app_mode,
    output logic           ram_en,
    output logic           rom_exec_en,
    output logic           ram_cs,
    output logic [SW-1:0]  ram_we,
    output logic [RAW-1:0] ram_addr,
    output logic [DW-1:0]  ram_wdata,
    input  logic [DW-1:0]  ram_rdata
);
    dec_t dec;

    spg_decode #(.AW(AW), .SW(SW)) u_dec (
        .cs   (bus_cs),
        .we   (bus_we),
        .addr (bus_addr),
        .dec  (dec)
    );

    spg_ctx u_ctx (
        .clk         (clk),
        .rst         (rst),
        .app_enter   (app_enter),
        .irq_ret     (irq_ret),
        .dec         (dec),
        .irq_hi      (irq_hi),
        .irq_lo      (irq_lo),
        .app_mode    (app_mode),
        .ram_en      (ram_en),
        .rom_exec_en (rom_exec_en)
    );

    spg_ramgate #(.AW(AW), .DW(DW), .SW(SW), .RAW(RAW)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .ram_en    (ram_en),
        .dec       (dec),
        .bus_cs    (bus_cs),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .ram_cs    (ram_cs),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata)
    );
endmodule

// File: rtl/spg_checker.sv
module spg_checker
    import spg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SW = DW / 8
) (
    input logic          clk,
    input logic          rst,
    input logic          app_enter,
    input logic          irq_ret,
    input logic          bus_cs,
    input logic [SW-1:0] bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic          bus_ready,
    input logic          irq_hi,
    input logic          irq_lo,
    input logic          app_mode,
    input logic          ram_en,
    input logic          rom_exec_en,
    input logic          ram_cs,
    input logic [SW-1:0] ram_we
);
    // R2: a trigger write to the high address raises irq_hi next cycle
    p_trig_hi_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && bus_we != '0 && 32'(bus_addr) == TRIG_HI_ADDR) |=> irq_hi);

    // R3: a trigger write to the low address raises irq_lo next cycle
    p_trig_lo_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && bus_we != '0 && 32'(bus_addr) == TRIG_LO_ADDR) |=> irq_lo);

    // R4: the high level, seen as ram_en in app mode, holds until a return
    p_lvl_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (app_mode && ram_en && !irq_ret) |=> ram_en);

    // R5: firmware mode always grants the RAM
    p_fw_ram_r5: assert property (@(posedge clk) disable iff (rst)
        !app_mode |-> ram_en);

    // R6: whenever the RAM is granted, ROM execution is granted too
    p_rom_r6: assert property (@(posedge clk) disable iff (rst)
        ram_en |-> rom_exec_en);

    // R7: no select or strobe reaches the RAM while it is disabled
    p_mask_r7: assert property (@(posedge clk) disable iff (rst)
        !ram_en |-> (!ram_cs && ram_we == '0));

    // R8: a denied access reads back zero
    p_rdata_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_cs && !ram_en) |=> bus_rdata == '0);

    // R9: every strobe completes next cycle, none spuriously
    p_ready_r9: assert property (@(posedge clk) disable iff (rst)
        bus_cs |=> bus_ready);
    p_noready_r9: assert property (@(posedge clk) disable iff (rst)
        !bus_cs |=> !bus_ready);

    // R10: application mode is entered on request and is sticky
    p_enter_r10: assert property (@(posedge clk) disable iff (rst)
        app_enter |=> app_mode);
    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        app_mode |=> app_mode);

    // R11: reads never raise an interrupt request
    p_read_noirq_r11: assert property (@(posedge clk) disable iff (rst)
        (!bus_cs || bus_we == '0) |=> (!irq_hi && !irq_lo));
endmodule

bind syscall_priv_gate spg_checker #(.AW(AW), .DW(DW), .SW(SW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .app_enter   (app_enter),
    .irq_ret     (irq_ret),
    .bus_cs      (bus_cs),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_ready   (bus_ready),
    .irq_hi      (irq_hi),
    .irq_lo      (irq_lo),
    .app_mode    (app_mode),
    .ram_en      (ram_en),
    .rom_exec_en (rom_exec_en),
    .ram_cs      (ram_cs),
    .ram_we      (ram_we)
);

// File: tb/sim_syscall_priv_gate.sv
`timescale 1ns/1ps
module sim_syscall_priv_gate;
    localparam logic [31:0] HI   = 32'hE100_0000;
    localparam logic [31:0] LO   = 32'hE000_0000;
    localparam logic [31:0] RAMA = 32'hD000_0010;
    localparam logic [31:0] RDAT = 32'h5555_AAAA;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic app_enter = 1'b0, irq_ret = 1'b0, bus_cs = 1'b0;
    logic [3:0]  bus_we = '0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] ram_rdata = RDAT;
    logic [31:0] bus_rdata, ram_wdata;
    logic bus_ready, irq_hi, irq_lo, app_mode, ram_en, rom_exec_en, ram_cs;
    logic [3:0] ram_we;
    logic [8:0] ram_addr;

    always #4 clk = ~clk;

    syscall_priv_gate u0 (
        .clk(clk), .rst(rst), .app_enter(app_enter), .irq_ret(irq_ret),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .irq_hi(irq_hi), .irq_lo(irq_lo), .app_mode(app_mode),
        .ram_en(ram_en), .rom_exec_en(rom_exec_en), .ram_cs(ram_cs),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    typedef struct {
        logic        ready;
        logic [31:0] rdata;
        logic        ihi;
        logic        ilo;
        logic        ren;
        logic        xen;
        logic        app;
        string       note;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    logic m_app = 1'b0, m_hi = 1'b0, m_lo = 1'b0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // driver: applies one cycle of stimulus, checks the same-cycle RAM
    // qualification and queues what the registered outputs must show next
    task automatic drive(input logic cs, input logic [3:0] we,
                         input logic [31:0] addr, input logic [31:0] wd,
                         input logic ret, input logic enter, input string note);
        exp_t e;
        logic th, tl, inr, en_now, ecs;
        @(negedge clk);
        bus_cs = cs; bus_we = we; bus_addr = addr; bus_wdata = wd;
        irq_ret = ret; app_enter = enter;
        th     = cs && we != 0 && addr == HI;
        tl     = cs && we != 0 && addr == LO;
        inr    = addr[31:24] == 8'hD0;
        en_now = !m_app || m_hi;
        ecs    = cs && inr && en_now;
        #1;
        chk(ram_cs == ecs, "R7", {note, " ram_cs"}, 32'(ram_cs), 32'(ecs));
        chk(ram_we == (ecs ? we : 4'h0), "R7", {note, " ram_we"},
            32'(ram_we), 32'(ecs ? we : 4'h0));
        m_hi  = th | (m_hi & ~ret);
        m_lo  = tl | (m_lo & ~ret);
        m_app = m_app | enter;
        e.ready = cs;
        e.rdata = (cs && we == 0 && inr && en_now) ? RDAT : 32'h0;
        e.ihi   = th;
        e.ilo   = tl;
        e.ren   = !m_app || m_hi;
        e.xen   = !m_app || m_hi || m_lo;
        e.app   = m_app;
        e.note  = note;
        q.push_back(e);
    endtask

    task automatic idle(input string note);
        drive(1'b0, 4'h0, 32'h0, 32'h0, 1'b0, 1'b0, note);
    endtask

    // monitor: pops one expectation per cycle after the edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(bus_ready == e.ready, "R9", {e.note, " ready"}, 32'(bus_ready), 32'(e.ready));
            chk(bus_rdata == e.rdata, "R8", {e.note, " rdata"}, bus_rdata, e.rdata);
            chk(irq_hi == e.ihi, "R2", {e.note, " irq_hi"}, 32'(irq_hi), 32'(e.ihi));
            chk(irq_lo == e.ilo, "R3", {e.note, " irq_lo"}, 32'(irq_lo), 32'(e.ilo));
            chk(ram_en == e.ren, "R5", {e.note, " ram_en"}, 32'(ram_en), 32'(e.ren));
            chk(rom_exec_en == e.xen, "R6", {e.note, " rom_exec_en"}, 32'(rom_exec_en), 32'(e.xen));
            chk(app_mode == e.app, "R10", {e.note, " app_mode"}, 32'(app_mode), 32'(e.app));
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        chk(app_mode == 1'b0, "R1", "reset app_mode", 32'(app_mode), 0);
        chk(irq_hi == 1'b0 && irq_lo == 1'b0, "R1", "reset irqs", 32'({irq_hi, irq_lo}), 0);
        chk(bus_ready == 1'b0, "R1", "reset ready", 32'(bus_ready), 0);
        chk(ram_en && rom_exec_en, "R1", "reset enables", 32'({ram_en, rom_exec_en}), 3);
        @(negedge clk);
        rst = 1'b0;

        // firmware mode: RAM fully usable (R5, R7, R8, R9)
        drive(1'b1, 4'hF, RAMA, 32'h1234_5678, 1'b0, 1'b0, "fw write R7");
        drive(1'b1, 4'h0, RAMA, 32'h0, 1'b0, 1'b0, "fw read R8");
        drive(1'b1, 4'h3, RAMA, 32'h0, 1'b0, 1'b0, "fw partial write R7");
        idle("fw idle R9");
        // R11: read of trigger addresses
        drive(1'b1, 4'h0, HI, 32'h0, 1'b0, 1'b0, "R11 read hi trigger");
        drive(1'b1, 4'h0, LO, 32'h0, 1'b0, 1'b0, "R11 read lo trigger");
        // R10: enter application mode
        drive(1'b0, 4'h0, 32'h0, 32'h0, 1'b0, 1'b1, "R10 enter app");
        idle("R10 app hold");
        // app mode: RAM invisible, ready still returned
        drive(1'b1, 4'h0, RAMA, 32'h0, 1'b0, 1'b0, "app read R8");
        drive(1'b1, 4'hF, RAMA, 32'hDEAD_BEEF, 1'b0, 1'b0, "app write R7");
        // R2: high trigger with zero data, then with ones
        drive(1'b1, 4'hF, HI, 32'h0, 1'b0, 1'b0, "R2 hi trigger data0");
        drive(1'b1, 4'h0, RAMA, 32'h0, 1'b0, 1'b0, "R4 hi read R8");
        drive(1'b1, 4'h1, RAMA, 32'h0, 1'b0, 1'b0, "R4 hi write R7");
        idle("R4 hi hold");
        drive(1'b0, 4'h0, 32'h0, 32'h0, 1'b1, 1'b0, "R4 return hi");
        drive(1'b1, 4'h0, RAMA, 32'h0, 1'b0, 1'b0, "R4 after return R8");
        drive(1'b1, 4'h8, HI, 32'hFFFF_FFFF, 1'b0, 1'b0, "R2 hi trigger data1");
        // R4: trigger and return in the same cycle, trigger wins
        drive(1'b1, 4'hF, HI, 32'h0, 1'b1, 1'b0, "R4 trigger with return");
        drive(1'b0, 4'h0, 32'h0, 32'h0, 1'b1, 1'b0, "R4 return");
        // R3: low trigger: ROM executable, RAM still invisible
        drive(1'b1, 4'hF, LO, 32'hA5A5_A5A5, 1'b0, 1'b0, "R3 lo trigger");
        drive(1'b1, 4'h0, RAMA, 32'h0, 1'b0, 1'b0, "R3 lo read R8");
        drive(1'b1, 4'hF, RAMA, 32'h0, 1'b0, 1'b0, "R3 lo write R7");
        // both levels, then return clears both
        drive(1'b1, 4'hF, HI, 32'h0, 1'b0, 1'b0, "R2 hi over lo");
        idle("R6 both levels");
        drive(1'b0, 4'h0, 32'h0, 32'h0, 1'b1, 1'b0, "R4 return both");
        idle("R6 app only");
        idle("final");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule